// File: doc/BRIEF.md
# Receive Key Cache Table

This block holds the cipher keys that a wireless MAC receive path needs to decrypt frames. Software programs it through a simple 32-bit register write port. Each entry carries five key words, one cipher type word and two station address words. A 32-bit read port returns the stored words. Internally every pair of neighbouring words shares one 64-bit storage cell. A cell changes only when the odd word of its pair is written. At that moment the cell takes the odd word together with the even word that was staged before it, so a half-written key is never visible.

The receive path asks for a key by pulsing a start strobe. With the strobe it gives the 48-bit transmitter address and a flag saying whether the frame is group-addressed. The block then scans entries 0 to 63, one per clock, and the lowest matching entry wins. It answers with a one-cycle done pulse, the hit flag, the entry index, the cipher type and the 128-bit key. For TKIP entries it also returns the receive and transmit Michael keys, which it takes from the companion entry 64 places higher.

Top module: `key_cache_table`

## Requirements
- R1: After reset, every word of every entry reads back as zero, except the cipher type word (word 5), which reads 7 (clear). No lookup of either kind hits.
- R2: A write to an even word only stages the data. Until the odd partner is written, a read of the even word returns the value committed earlier.
- R3: A write to an odd word commits one 64-bit cell. Its low half is the most recently staged even data and its high half is the odd data. The staged data is one global register, so an odd write with no even write before it reuses the last even data written to any cell.
- R4: Register address = entry × 8 + word; the address is 10 bits for 128 entries. The words are: 0 to 4 = key words 0 to 4, 5 = cipher type in bits 2:0, 6 = address bits 32:1, and 7 = address bits 47:33 in bits 14:0 with the unicast valid flag in bit 15. The cells are formed by the pairs (0,1), (2,3), (4,5) and (6,7).
- R5: When rd_en is sampled at a rising edge, rd_valid is high and rd_data holds the word for the cycle that follows the next rising edge.
- R6: A unicast lookup matches an entry whose valid flag is set and whose stored 47 address bits equal lk_addr[47:1]. lk_addr[0] is ignored.
- R7: A group lookup matches an entry whose valid flag is clear and whose cipher type is not 7. Entries with the valid flag set never match a group lookup.
- R8: Only entries 0 to 63 are scanned, and the lowest matching index is reported. A miss returns hit = 0, index 0, type 7, and a key and Michael keys of zero.
- R9: The reported key is {key4, key3[15:0], key2, key1[15:0], key0}, with key0 in bits 31:0. For type 0 (40-bit WEP) and type 1 (104-bit WEP), only key4[7:0] is kept and bits 127:104 are zero.
- R10: For type 4 (TKIP), the Michael keys come from entry index+64. The receive key is {w2, w0} and the transmit key is {w4, w1[15:0], w3[15:0]}, where wN is word N of that entry. For every other type, both Michael outputs are zero.
- R11: lk_done is high for exactly one cycle per accepted lookup. The result outputs then hold their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Write address {entry, word} |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 10 | Read address {entry, word} |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | rd_data is valid |
| lk_start | input | 1 | Start a lookup (accepted when idle) |
| lk_addr | input | 48 | Transmitter address |
| lk_group | input | 1 | 1 = group-addressed frame, 0 = unicast |
| lk_done | output | 1 | Lookup result pulse |
| lk_hit | output | 1 | An entry matched |
| lk_index | output | 7 | Matching entry index |
| lk_type | output | 3 | Cipher type of the match |
| lk_key | output | 128 | Packed key of the match |
| lk_rx_mic | output | 64 | Receive Michael key (TKIP only) |
| lk_tx_mic | output | 64 | Transmit Michael key (TKIP only) |

## Verification
The assertions run on every cycle and cover four things:
- the read latency;
- that the done pulse is a single cycle;
- that a reported index always lies inside the scan window;
- that the WEP key masking and the TKIP-only Michael outputs hold whenever a result appears.

Other behaviour can only be shown by the bench's scenarios, because it depends on what was written earlier. This includes staging without commit, the reuse of an orphan odd write, address matching that ignores bit 0, the lowest-index priority, entries above 63 staying invisible, and the layout of the companion Michael keys.

// File: rtl/kc_pkg.sv
package kc_pkg;
  typedef enum logic [2:0] {
    CT_WEP40   = 3'd0,
    CT_WEP104  = 3'd1,
    CT_AES_OCB = 3'd2,
    CT_WEP128  = 3'd3,
    CT_TKIP    = 3'd4,
    CT_AES_CCM = 3'd5,
    CT_CLEAR   = 3'd7
  } cipher_e;

  localparam int CELLS_PER_ENTRY = 4;
  localparam int WORD_SEL_W      = 3;
  localparam int CELL_KEYLO      = 0;   // words 0,1
  localparam int CELL_KEYMID     = 1;   // words 2,3
  localparam int CELL_KEYTYPE    = 2;   // words 4,5
  localparam int CELL_ADDR       = 3;   // words 6,7
  localparam int VALID_BIT       = 15;  // in word 7
  localparam int MAC_W           = 48;
endpackage

// File: rtl/kc_stage.sv
// Pairs 32-bit register writes into 64-bit cell commits.
module kc_stage #(
  parameter int ENTRY_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [2:0]         wr_word,
  input  logic [31:0]        wr_data,
  output logic               commit,
  output logic [ENTRY_W-1:0] c_entry,
  output logic [1:0]         c_cell,
  output logic [63:0]        c_data
);
  logic [31:0] staged_q;

  // Even word: hold it until its odd partner arrives (one global holding register).
  always_ff @(posedge clk) begin
    if (rst)
      staged_q <= '0;
    else if (wr_en && !wr_word[0])
      staged_q <= wr_data;
  end

  assign commit  = wr_en & wr_word[0];
  assign c_entry = wr_entry;
  assign c_cell  = wr_word[2:1];
  assign c_data  = {wr_data, staged_q};
endmodule

// File: rtl/kc_bank.sv
// One 64-bit cell column across all entries: one write port and two registered read ports.
// Cells never written since reset read back as RST_VAL.
module kc_bank #(
  parameter int          DEPTH   = 128,
  parameter int          AW      = 7,
  parameter logic [63:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [63:0]   wdata,
  input  logic [AW-1:0] a_addr,
  output logic [63:0]   a_q,
  input  logic [AW-1:0] b_addr,
  output logic [63:0]   b_q
);
  logic [63:0]    mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [63:0]    ma_q, mb_q;
  logic           wa_q, wb_q;

  // Storage array: no reset, so it can map to RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ma_q <= mem[a_addr];
    mb_q <= mem[b_addr];
  end

  // Per-cell "written since reset" flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      wa_q    <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      wa_q <= written[a_addr];
      wb_q <= written[b_addr];
    end
  end

  assign a_q = wa_q ? ma_q : RST_VAL;
  assign b_q = wb_q ? mb_q : RST_VAL;
endmodule

// File: rtl/kc_scan.sv
// Sequential lookup engine: one entry per clock, lowest index wins, then fetch of the companion Michael keys.
module kc_scan
  import kc_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int SCAN_N  = 64,
  parameter int MIC_OFS = 64,
  parameter int AW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [47:0]   addr_in,
  input  logic          group_in,
  output logic [AW-1:0] rd_addr,
  input  logic [63:0]   q0,
  input  logic [63:0]   q1,
  input  logic [63:0]   q2,
  input  logic [63:0]   q3,
  output logic          done,
  output logic          hit,
  output logic [AW-1:0] index,
  output logic [2:0]    ctype,
  output logic [127:0]  key,
  output logic [63:0]   rx_mic,
  output logic [63:0]   tx_mic
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_MICRD, S_MICCAP} state_e;

  localparam logic [AW-1:0] LAST_IDX = AW'(SCAN_N - 1);
  localparam logic [AW-1:0] MIC_STEP = AW'(MIC_OFS);

  state_e        state;
  logic [AW-1:0] idx, eval_idx, hit_idx;
  logic          eval_v;
  logic [46:0]   tgt;
  logic          grp;
  logic [2:0]    type_q;
  logic [127:0]  key_q;

  // Decode the cell words of the entry now on the read port.
  logic [31:0] w6, w7, k4m;
  logic [2:0]  ty;
  logic        vflag, m_uni, m_grp, match, wep_short;
  logic        unused_ok;

  assign w6        = q3[31:0];
  assign w7        = q3[63:32];
  assign ty        = q2[34:32];
  assign vflag     = w7[VALID_BIT];
  assign m_uni     = vflag && ({w7[14:0], w6} == tgt);
  assign m_grp     = !vflag && (ty != CT_CLEAR);
  assign match     = eval_v && (grp ? m_grp : m_uni);
  assign wep_short = (ty == CT_WEP40) || (ty == CT_WEP104);
  assign k4m       = wep_short ? {24'd0, q2[7:0]} : q2[31:0];
  assign unused_ok = ^{q2[63:35], w7[31:16], addr_in[0]};

  assign rd_addr = (state == S_MICRD) ? hit_idx + MIC_STEP : idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      idx      <= '0;
      eval_idx <= '0;
      eval_v   <= 1'b0;
      hit_idx  <= '0;
      tgt      <= '0;
      grp      <= 1'b0;
      type_q   <= CT_CLEAR;
      key_q    <= '0;
      done     <= 1'b0;
      hit      <= 1'b0;
      index    <= '0;
      ctype    <= CT_CLEAR;
      key      <= '0;
      rx_mic   <= '0;
      tx_mic   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            tgt    <= addr_in[47:1];
            grp    <= group_in;
            idx    <= '0;
            eval_v <= 1'b0;
            state  <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (match) begin
            hit_idx <= eval_idx;
            type_q  <= ty;
            key_q   <= {k4m, q1[47:32], q1[31:0], q0[47:32], q0[31:0]};
            state   <= S_MICRD;
          end else if (eval_v && eval_idx == LAST_IDX) begin
            done   <= 1'b1;
            hit    <= 1'b0;
            index  <= '0;
            ctype  <= CT_CLEAR;
            key    <= '0;
            rx_mic <= '0;
            tx_mic <= '0;
            state  <= S_IDLE;
          end else begin
            eval_idx <= idx;
            eval_v   <= 1'b1;
            idx      <= idx + 1'b1;
          end
        end
        S_MICRD: state <= S_MICCAP;
        S_MICCAP: begin
          done  <= 1'b1;
          hit   <= 1'b1;
          index <= hit_idx;
          ctype <= type_q;
          key   <= key_q;
          if (type_q == CT_TKIP) begin
            rx_mic <= {q1[31:0], q0[31:0]};
            tx_mic <= {q2[31:0], q0[47:32], q1[47:32]};
          end else begin
            rx_mic <= '0;
            tx_mic <= '0;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: the result strobe lasts exactly one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a reported hit lies inside the scan window
  p_hit_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    (done && hit) |-> (index < AW'(SCAN_N)));

  // R9: short WEP keys carry only 8 bits of key word 4
  p_key_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (done && hit && (ctype == CT_WEP40 || ctype == CT_WEP104)) |-> (key[127:104] == '0));

  // R10: Michael outputs are zero unless the cipher is TKIP
  p_mic_tkip_only_r10: assert property (@(posedge clk) disable iff (rst)
    (done && ctype != CT_TKIP) |-> (rx_mic == '0 && tx_mic == '0));
endmodule

// File: rtl/key_cache_table.sv
module key_cache_table
  import kc_pkg::*;
#(
  parameter int ENTRIES = 128,
  parameter int SCAN_N  = 64,
  parameter int MIC_OFS = 64,
  localparam int AW     = $clog2(ENTRIES),
  localparam int RAW    = AW + WORD_SEL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           rd_en,
  input  logic [RAW-1:0] rd_addr,
  output logic [31:0]    rd_data,
  output logic           rd_valid,
  input  logic           lk_start,
  input  logic [47:0]    lk_addr,
  input  logic           lk_group,
  output logic           lk_done,
  output logic           lk_hit,
  output logic [AW-1:0]  lk_index,
  output logic [2:0]     lk_type,
  output logic [127:0]   lk_key,
  output logic [63:0]    lk_rx_mic,
  output logic [63:0]    lk_tx_mic
);
  logic          commit;
  logic [AW-1:0] c_entry;
  logic [1:0]    c_cell;
  logic [63:0]   c_data;
  logic [AW-1:0] scan_addr;
  logic [63:0]   qa [CELLS_PER_ENTRY];
  logic [63:0]   qb [CELLS_PER_ENTRY];

  kc_stage #(.ENTRY_W(AW)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_entry(wr_addr[RAW-1:WORD_SEL_W]),
    .wr_word (wr_addr[WORD_SEL_W-1:0]),
    .wr_data (wr_data),
    .commit  (commit),
    .c_entry (c_entry),
    .c_cell  (c_cell),
    .c_data  (c_data)
  );

  for (genvar c = 0; c < CELLS_PER_ENTRY; c++) begin : g_cell
    localparam logic [63:0] RV = (c == CELL_KEYTYPE) ? {29'd0, 3'(CT_CLEAR), 32'd0} : 64'd0;
    kc_bank #(.DEPTH(ENTRIES), .AW(AW), .RST_VAL(RV)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (commit && (c_cell == 2'(c))),
      .waddr (c_entry),
      .wdata (c_data),
      .a_addr(rd_addr[RAW-1:WORD_SEL_W]),
      .a_q   (qa[c]),
      .b_addr(scan_addr),
      .b_q   (qb[c])
    );
  end

  // Host read: bank stage, then word select into an output register.
  logic       rd_pend;
  logic [2:0] rd_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      rd_sel_q <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_pend  <= rd_en;
      rd_sel_q <= rd_addr[WORD_SEL_W-1:0];
      rd_valid <= rd_pend;
      if (rd_pend)
        rd_data <= rd_sel_q[0] ? qa[rd_sel_q[2:1]][63:32] : qa[rd_sel_q[2:1]][31:0];
    end
  end

  kc_scan #(.ENTRIES(ENTRIES), .SCAN_N(SCAN_N), .MIC_OFS(MIC_OFS), .AW(AW)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .start   (lk_start),
    .addr_in (lk_addr),
    .group_in(lk_group),
    .rd_addr (scan_addr),
    .q0      (qb[CELL_KEYLO]),
    .q1      (qb[CELL_KEYMID]),
    .q2      (qb[CELL_KEYTYPE]),
    .q3      (qb[CELL_ADDR]),
    .done    (lk_done),
    .hit     (lk_hit),
    .index   (lk_index),
    .ctype   (lk_type),
    .key     (lk_key),
    .rx_mic  (lk_rx_mic),
    .tx_mic  (lk_tx_mic)
  );

  // R5: read data appears two edges after the request
  p_rd_latency_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2));
endmodule

// File: tb/sim_key_cache_table.sv
module sim_key_cache_table;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en, rd_en, lk_start, lk_group;
  logic [9:0]   wr_addr, rd_addr;
  logic [31:0]  wr_data, rd_data;
  logic         rd_valid, lk_done, lk_hit;
  logic [47:0]  lk_addr;
  logic [6:0]   lk_index;
  logic [2:0]   lk_type;
  logic [127:0] lk_key;
  logic [63:0]  lk_rx_mic, lk_tx_mic;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // lookup results captured at the done pulse
  logic         r_hit;
  logic [6:0]   r_idx;
  logic [2:0]   r_type;
  logic [127:0] r_key;
  logic [63:0]  r_rx, r_tx;

  always #5 clk = ~clk;

  key_cache_table u0 (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .lk_start(lk_start), .lk_addr(lk_addr), .lk_group(lk_group),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_index(lk_index), .lk_type(lk_type),
    .lk_key(lk_key), .lk_rx_mic(lk_rx_mic), .lk_tx_mic(lk_tx_mic)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int e, input int w, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {7'(e), 3'(w)}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int e, input int w, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = {7'(e), 3'(w)};
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid == 1'b0, "R5 early valid", 128'(rd_valid), 128'd0);
    @(negedge clk);
    check(rd_valid == 1'b1, "R5 valid", 128'(rd_valid), 128'd1);
    d = rd_data;
  endtask

  task automatic prog(input int e, input logic [31:0] k0, k1, k2, k3, k4,
                      input logic [2:0] ty, input logic [47:0] mac, input bit uni);
    wr(e, 0, k0); wr(e, 1, k1);
    wr(e, 2, k2); wr(e, 3, k3);
    wr(e, 4, k4); wr(e, 5, {29'd0, ty});
    wr(e, 6, mac[32:1]); wr(e, 7, {16'd0, uni, mac[47:33]});
  endtask

  task automatic lookup(input logic [47:0] a, input bit g);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    lk_start = 1'b1; lk_addr = a; lk_group = g;
    @(negedge clk);
    lk_start = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      if (lk_done) begin
        seen = 1'b1;
        r_hit = lk_hit; r_idx = lk_index; r_type = lk_type;
        r_key = lk_key; r_rx = lk_rx_mic; r_tx = lk_tx_mic;
      end else
        @(negedge clk);
    end
    check(seen, "R11 done seen", 128'(seen), 128'd1);
    @(negedge clk);
    check(lk_done == 1'b0, "R11 single pulse", 128'(lk_done), 128'd0);
    check(lk_index == r_idx && lk_hit == r_hit, "R11 result held",
          128'({lk_hit, lk_index}), 128'({r_hit, r_idx}));
  endtask

  task automatic expect_miss(input string tag);
    check(r_hit == 1'b0, tag, 128'(r_hit), 128'd0);
    check(r_type == 3'd7 && r_key == '0 && r_rx == '0 && r_tx == '0 && r_idx == '0,
          "R8 miss fields", {r_key[63:0], 57'd0, r_idx}, {64'd0, 57'd0, 7'd0});
  endtask

  localparam logic [47:0] M1 = 48'h0242_ACDE_0F10;
  localparam logic [47:0] M2 = 48'h1234_5678_9ABC;
  localparam logic [47:0] M3 = 48'h00AA_BB11_2233;

  task automatic t_reset;
    logic [31:0] d;
    rd(0, 5, d);   check(d == 32'd7, "R1 type after reset", 128'(d), 128'd7);
    rd(5, 0, d);   check(d == 32'd0, "R1 key0 after reset", 128'(d), 128'd0);
    rd(127, 7, d); check(d == 32'd0, "R1 addr1 after reset", 128'(d), 128'd0);
    lookup(48'd0, 1'b1); expect_miss("R1 group miss after reset");
    lookup(48'd0, 1'b0); expect_miss("R1 unicast miss after reset");
  endtask

  task automatic t_stage;
    logic [31:0] d;
    wr(3, 0, 32'hA5A5_0001);
    rd(3, 0, d); check(d == 32'd0, "R2 even staged only", 128'(d), 128'd0);
    wr(3, 1, 32'h0000_B002);
    rd(3, 0, d); check(d == 32'hA5A5_0001, "R3 commit low", 128'(d), 128'hA5A5_0001);
    rd(3, 1, d); check(d == 32'h0000_B002, "R3 commit high", 128'(d), 128'h0000_B002);
  endtask

  task automatic t_orphan_odd;
    logic [31:0] d;
    wr(4, 2, 32'hC0C0_C0C0);
    wr(10, 1, 32'hD00D_0001);
    rd(10, 0, d); check(d == 32'hC0C0_C0C0, "R3 orphan odd reuses stage", 128'(d), 128'hC0C0_C0C0);
    rd(4, 2, d);  check(d == 32'd0, "R2 uncommitted even", 128'(d), 128'd0);
  endtask

  task automatic t_unicast;
    logic [31:0] d;
    prog(7, 32'h1122_3344, 32'hAAAA_5678, 32'h5566_7788, 32'hBBBB_9ABC, 32'hDEAD_BEEF, 3'd1, M1, 1'b1);
    prog(71, 32'h1, 32'h2, 32'h3, 32'h4, 32'h5, 3'd7, 48'd0, 1'b0);
    rd(7, 5, d); check(d == 32'd1, "R4 type word", 128'(d), 128'd1);
    rd(7, 6, d); check(d == M1[32:1], "R4 addr word0", 128'(d), 128'(M1[32:1]));
    rd(7, 7, d); check(d == {16'd0, 1'b1, M1[47:33]}, "R4 addr word1", 128'(d), 128'({16'd0, 1'b1, M1[47:33]}));
    lookup(M1, 1'b0);
    check(r_hit && r_idx == 7 && r_type == 3'd1, "R6 unicast hit",
          128'({r_hit, r_idx, r_type}), 128'({1'b1, 7'd7, 3'd1}));
    check(r_key == {32'h0000_00EF, 16'h9ABC, 32'h5566_7788, 16'h5678, 32'h1122_3344},
          "R9 key layout and mask", r_key, {32'h0000_00EF, 16'h9ABC, 32'h5566_7788, 16'h5678, 32'h1122_3344});
    check(r_rx == '0 && r_tx == '0, "R10 non-TKIP mic zero", {r_rx, r_tx}, 128'd0);
    lookup(M1 | 48'd1, 1'b0);
    check(r_hit && r_idx == 7, "R6 addr bit0 ignored", 128'({r_hit, r_idx}), 128'({1'b1, 7'd7}));
    lookup(M1 ^ 48'd2, 1'b0); expect_miss("R6 mismatch misses");
    lookup(48'd0, 1'b1); expect_miss("R7 unicast entry not group");
  endtask

  task automatic t_group_lowest;
    prog(20, 32'h20, 32'h0, 32'h0, 32'h0, 32'h0, 3'd5, 48'd0, 1'b0);
    prog(12, 32'h12, 32'h0, 32'h0, 32'h0, 32'h0, 3'd2, 48'd0, 1'b0);
    lookup(48'hFFFF_FFFF_FFFF, 1'b1);
    check(r_hit && r_idx == 12 && r_type == 3'd2, "R7 group lowest match",
          128'({r_hit, r_idx, r_type}), 128'({1'b1, 7'd12, 3'd2}));
    prog(40, 32'h40, 32'h0, 32'h0, 32'h0, 32'h0, 3'd3, M1, 1'b1);
    lookup(M1, 1'b0);
    check(r_hit && r_idx == 7, "R8 lowest index wins", 128'({r_hit, r_idx}), 128'({1'b1, 7'd7}));
    prog(70, 32'h70, 32'h0, 32'h0, 32'h0, 32'h0, 3'd3, M2, 1'b1);
    lookup(M2, 1'b0); expect_miss("R8 entry above window ignored");
  endtask

  task automatic t_tkip;
    prog(30, 32'hA0A0_0001, 32'h0000_1357, 32'hB0B0_0002, 32'h0000_2468, 32'hCAFE_F00D, 3'd4, M3, 1'b1);
    prog(94, 32'h0102_0304, 32'hFFFF_1111, 32'h0506_0708, 32'hEEEE_2222, 32'h0A0B_0C0D, 3'd7, 48'd0, 1'b0);
    lookup(M3, 1'b0);
    check(r_hit && r_idx == 30 && r_type == 3'd4, "R10 TKIP hit",
          128'({r_hit, r_idx, r_type}), 128'({1'b1, 7'd30, 3'd4}));
    check(r_key == {32'hCAFE_F00D, 16'h2468, 32'hB0B0_0002, 16'h1357, 32'hA0A0_0001},
          "R9 TKIP full key4", r_key, {32'hCAFE_F00D, 16'h2468, 32'hB0B0_0002, 16'h1357, 32'hA0A0_0001});
    check(r_rx == 64'h0506_0708_0102_0304, "R10 rx mic", 128'(r_rx), 128'h0506_0708_0102_0304);
    check(r_tx == 64'h0A0B_0C0D_1111_2222, "R10 tx mic", 128'(r_tx), 128'h0A0B_0C0D_1111_2222);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; lk_start = 1'b0; lk_group = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0; lk_addr = '0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0 && lk_done == 1'b0, "R1 outputs idle in reset",
          128'({rd_valid, lk_done}), 128'd0);
    rst = 1'b0;
    t_reset();
    t_stage();
    t_orphan_odd();
    t_unicast();
    t_group_lowest();
    t_tkip();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule